// File: doc/BRIEF.md
# Serial Channel Register Front End

This block sits between a host bus and the engine of one serial communications channel. The host sees only two byte-wide ports. The control port reaches a bank of sixteen write registers and a set of status read registers. The data port goes straight to the transmit and receive byte paths. Register 0 of the control port is always reachable. To reach any other register, the host first writes register 0 with a target address and then makes one more control access. That access reads or writes the selected register, after which the pointer returns home.

A write to register 0 can also carry commands. These fire one-cycle clear pulses toward the channel engine: clearing interrupt sources, errors, the CRC units and the underrun latch. A write to register 9 can reset the channel's mode registers or clear the whole bank. On the read side, the block assembles a pending-interrupt summary and an interrupt vector. The vector can optionally carry a status code. The read side also presents a frame byte count, which is gated by an enable bit in register 15.

Top module: `scc_regif`

## Requirements
- R1: In a control-port write with no pointer armed, bits 2:0 form the target address, and command code 1 in bits 5:3 adds 8 to it. A nonzero target arms the pointer, and the next control access (read or write) reaches that register. A zero target arms nothing.
- R2: Once the armed access has completed, the pointer returns to 0. An unarmed control read then returns the status input `st_rr0`.
- R3: In an unarmed control write, the code in bits 5:3 drives `cmd_pulse`. Code 2 drives bit 0 (external/status clear), 5 drives bit 1 (transmit pending clear), 6 drives bit 2 (error reset) and 7 drives bit 3 (in-service clear). The pulse is high for exactly the one cycle after the write edge.
- R4: In the same write, the code in bits 7:6 drives `cmd_pulse` with the same timing. Code 1 drives bit 4 (receive CRC reset), 2 drives bit 5 (transmit CRC reset) and 3 drives bit 6 (underrun latch reset).
- R5: An armed control write stores the byte in register k. The register appears on `wr_bank[8k+7:8k]` after the write edge. Byte 0 of `wr_bank` is always 0.
- R6: A data-port write stores the byte as register 8 and pulses `tx_load` for one cycle. An armed control write to register 8 does the same. A data-port read returns `rx_byte`. Data-port accesses leave the pointer unchanged.
- R7: Read register 3 returns the receive pending input at bit 5, the transmit pending input at bit 4 and the external/status pending input at bit 3. All other bits are 0.
- R8: Read register 2 returns register 2. When bit 0 of register 9 is set, bits 3:1 are replaced by a status code: 010 for receive, else 000 for transmit, else 001 for external/status, else 011 when nothing is pending.
- R9: Read register 6 returns count bits 7:0. Read register 7 returns {overflow, available, count bits 13:8}. Both read 0x00 while bit 2 of register 15 is clear.
- R10: A register-9 write with bits 7:6 equal to 2 clears every register except 2 and 9, stores bits 5:0 in register 9 and pulses `chan_rst`. A write with bits 7:6 equal to 3 clears the whole bank and pulses `hard_rst`. In all register-9 writes, bits 7:6 of the stored value read 0.
- R11: Control reads of addresses 4, 5, 9, 11 and 14 return 0x00 and change no register.
- R12: Read registers 12, 13 and 15 return the written registers 12, 13 and 15. Read register 1 returns `st_rr1`, read register 8 returns `rx_byte`, and read register 10 returns `st_rr10`.
- R13: After reset, the bank is all zero, no pointer is armed, and all pulse outputs are low. `rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Host access in this cycle |
| acc_data | input | 1 | 1 selects the data port, 0 selects the control port |
| acc_wr | input | 1 | 1 for write, 0 for read |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the access cycle |
| st_rr0 | input | 8 | Buffer and external status from the engine |
| st_rr1 | input | 8 | Special receive condition status |
| st_rr10 | input | 8 | Miscellaneous status |
| rx_byte | input | 8 | Received character |
| ip_rx | input | 1 | Receive interrupt pending |
| ip_tx | input | 1 | Transmit interrupt pending |
| ip_ext | input | 1 | External/status interrupt pending |
| fifo_cnt | input | 14 | Frame byte count |
| fifo_avail | input | 1 | Status FIFO has data |
| fifo_ovf | input | 1 | Status FIFO overflowed |
| wr_bank | output | 128 | Flattened write registers, byte k is register k |
| cmd_pulse | output | 7 | One-cycle command clears |
| tx_load | output | 1 | One-cycle transmit byte load |
| chan_rst | output | 1 | One-cycle channel reset |
| hard_rst | output | 1 | One-cycle full bank clear |

## Verification
The assertions check the following on every cycle:
- the pointer returns home after an armed access;
- data-port traffic leaves the pointer state untouched;
- at most one low-field command fires at a time, and every command pulse traces back to an unarmed control write;
- a bank clear coincides with `hard_rst`;
- unimplemented addresses read zero;
- read register 3 follows the pending inputs.

Only the bench scenarios can show the cross-register effects: vector modification by the enable bit in register 9, count gating by register 15, channel reset preserving registers 2 and 9, and point-high reaching the upper eight registers. These need a chosen sequence of writes followed by a read.

// File: rtl/scc_regif_pkg.sv
package scc_regif_pkg;

   // register-0 low command field (bits 5:3)
   localparam logic [2:0] CL_POINT_HIGH = 3'd1;
   localparam logic [2:0] CL_EXT_CLR    = 3'd2;
   localparam logic [2:0] CL_TXIP_CLR   = 3'd5;
   localparam logic [2:0] CL_ERR_CLR    = 3'd6;
   localparam logic [2:0] CL_IUS_CLR    = 3'd7;

   // register-9 reset field (bits 7:6)
   localparam logic [1:0] RS_CHANNEL = 2'd2;
   localparam logic [1:0] RS_HARD    = 2'd3;

   // register addresses with behaviour attached
   localparam int A_RR1  = 1;
   localparam int A_VEC  = 2;
   localparam int A_IP   = 3;
   localparam int A_CNTL = 6;
   localparam int A_CNTH = 7;
   localparam int A_BUF  = 8;
   localparam int A_MIC  = 9;
   localparam int A_RR10 = 10;
   localparam int A_TCL  = 12;
   localparam int A_TCH  = 13;
   localparam int A_XIE  = 15;

   // status code inserted into vector bits 3:1, receive first
   function automatic logic [2:0] vis_code(input logic rx, input logic tx, input logic ext);
      if (rx)       return 3'b010;
      else if (tx)  return 3'b000;
      else if (ext) return 3'b001;
      else          return 3'b011;
   endfunction

endpackage

// File: rtl/scc_regif_ptr.sv
module scc_regif_ptr
   import scc_regif_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_data,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed,
   output logic [IDX_W-1:0]  ptr,
   output logic              reg_we,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              chan_req,
   output logic              hard_req,
   output logic [6:0]        cmd_pulse,
   output logic              tx_load,
   output logic              chan_rst,
   output logic              hard_rst
);

   logic             ctl_wr, ctl_rd, data_wr, first_wr, second;
   logic [2:0]       cmd_lo;
   logic [1:0]       cmd_hi;
   logic [IDX_W-1:0] tgt;
   logic             wr9;
   logic [6:0]       cmd_d;

   always_comb begin
      ctl_wr   = acc_en & ~acc_data & acc_wr;
      ctl_rd   = acc_en & ~acc_data & ~acc_wr;
      data_wr  = acc_en & acc_data & acc_wr;
      first_wr = ctl_wr & ~armed;
      second   = (ctl_wr | ctl_rd) & armed;
      cmd_lo   = wdata[5:3];
      cmd_hi   = wdata[7:6];
      tgt      = IDX_W'(wdata[2:0]) + ((cmd_lo == CL_POINT_HIGH) ? IDX_W'(8) : '0);
      reg_we   = (ctl_wr & armed) | data_wr;
      reg_idx  = data_wr ? IDX_W'(A_BUF) : ptr;
      wr9      = ctl_wr & armed & (ptr == IDX_W'(A_MIC));
      chan_req = wr9 & (cmd_hi == RS_CHANNEL);
      hard_req = wr9 & (cmd_hi == RS_HARD);
      cmd_d[0] = first_wr & (cmd_lo == CL_EXT_CLR);
      cmd_d[1] = first_wr & (cmd_lo == CL_TXIP_CLR);
      cmd_d[2] = first_wr & (cmd_lo == CL_ERR_CLR);
      cmd_d[3] = first_wr & (cmd_lo == CL_IUS_CLR);
      cmd_d[4] = first_wr & (cmd_hi == 2'd1);
      cmd_d[5] = first_wr & (cmd_hi == 2'd2);
      cmd_d[6] = first_wr & (cmd_hi == 2'd3);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         ptr   <= '0;
      end else if (second) begin
         armed <= 1'b0;
         ptr   <= '0;
      end else if (first_wr && tgt != '0) begin
         armed <= 1'b1;
         ptr   <= tgt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_pulse <= '0;
         tx_load   <= 1'b0;
         chan_rst  <= 1'b0;
         hard_rst  <= 1'b0;
      end else begin
         cmd_pulse <= cmd_d;
         tx_load   <= reg_we & (reg_idx == IDX_W'(A_BUF));
         chan_rst  <= chan_req;
         hard_rst  <= hard_req;
      end
   end

endmodule

// File: rtl/scc_regif_bank.sv
module scc_regif_bank
   import scc_regif_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDX_W-1:0]           idx,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       chan_req,
   input  logic                       hard_req,
   output logic [NUM_REGS*DATA_W-1:0] bank
);

   localparam int LOW_W = DATA_W - 2;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      if (k == 0) begin : g_ptr_only
         assign bank[k*DATA_W +: DATA_W] = '0;
      end else if (k == A_MIC) begin : g_mic
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= '0;
            else if (hard_req)                     q <= '0;
            else if (we && idx == IDX_W'(k))       q <= {2'b00, wdata[LOW_W-1:0]};
         end
         assign bank[k*DATA_W +: DATA_W] = q;
      end else begin : g_plain
         localparam bit KEEP_ON_CHAN = (k == A_VEC);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= '0;
            else if (hard_req)                     q <= '0;
            else if (chan_req && !KEEP_ON_CHAN)    q <= '0;
            else if (we && idx == IDX_W'(k))       q <= wdata;
         end
         assign bank[k*DATA_W +: DATA_W] = q;
      end
   end

endmodule

// File: rtl/scc_regif_rdmux.sv
module scc_regif_rdmux
   import scc_regif_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int IDX_W        = 4,
   parameter int CNT_W        = 14,
   parameter bit HAS_FIFO_CNT = 1'b1
) (
   input  logic              acc_en,
   input  logic              acc_data,
   input  logic              acc_wr,
   input  logic              armed,
   input  logic [IDX_W-1:0]  ptr,
   input  logic [DATA_W-1:0] wr_vec,
   input  logic              vis_en,
   input  logic [DATA_W-1:0] wr_tcl,
   input  logic [DATA_W-1:0] wr_tch,
   input  logic [DATA_W-1:0] wr_xie,
   input  logic [DATA_W-1:0] st_rr0,
   input  logic [DATA_W-1:0] st_rr1,
   input  logic [DATA_W-1:0] st_rr10,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              ip_rx,
   input  logic              ip_tx,
   input  logic              ip_ext,
   input  logic [CNT_W-1:0]  fifo_cnt,
   input  logic              fifo_avail,
   input  logic              fifo_ovf,
   output logic [DATA_W-1:0] rdata
);

   localparam int HI_W = DATA_W - 2;

   logic [DATA_W-1:0] rr_cntl, rr_cnth, rr_vec, rr_ip, rr_sel;
   logic [IDX_W-1:0]  sel;

   if (HAS_FIFO_CNT) begin : g_cnt
      logic fifo_en;
      assign fifo_en = wr_xie[2];
      assign rr_cntl = fifo_en ? fifo_cnt[7:0] : '0;
      assign rr_cnth = fifo_en ? {fifo_ovf, fifo_avail, HI_W'(fifo_cnt[CNT_W-1:8])} : '0;
   end else begin : g_nocnt
      assign rr_cntl = '0;
      assign rr_cnth = '0;
   end

   always_comb begin
      rr_ip  = {2'b00, ip_rx, ip_tx, ip_ext, 3'b000};
      rr_vec = vis_en ? {wr_vec[7:4], vis_code(ip_rx, ip_tx, ip_ext), wr_vec[0]} : wr_vec;
      sel    = armed ? ptr : '0;
      case (sel)
         IDX_W'(0):      rr_sel = st_rr0;
         IDX_W'(A_RR1):  rr_sel = st_rr1;
         IDX_W'(A_VEC):  rr_sel = rr_vec;
         IDX_W'(A_IP):   rr_sel = rr_ip;
         IDX_W'(A_CNTL): rr_sel = rr_cntl;
         IDX_W'(A_CNTH): rr_sel = rr_cnth;
         IDX_W'(A_BUF):  rr_sel = rx_byte;
         IDX_W'(A_RR10): rr_sel = st_rr10;
         IDX_W'(A_TCL):  rr_sel = wr_tcl;
         IDX_W'(A_TCH):  rr_sel = wr_tch;
         IDX_W'(A_XIE):  rr_sel = wr_xie;
         default:        rr_sel = '0;
      endcase
      if (acc_en && !acc_wr) rdata = acc_data ? rx_byte : rr_sel;
      else                   rdata = '0;
   end

endmodule

// File: rtl/scc_regif.sv
module scc_regif
   import scc_regif_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int NUM_REGS     = 16,
   parameter int CNT_W        = 14,
   parameter bit HAS_FIFO_CNT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_en,
   input  logic                       acc_data,
   input  logic                       acc_wr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   input  logic [DATA_W-1:0]          st_rr0,
   input  logic [DATA_W-1:0]          st_rr1,
   input  logic [DATA_W-1:0]          st_rr10,
   input  logic [DATA_W-1:0]          rx_byte,
   input  logic                       ip_rx,
   input  logic                       ip_tx,
   input  logic                       ip_ext,
   input  logic [CNT_W-1:0]           fifo_cnt,
   input  logic                       fifo_avail,
   input  logic                       fifo_ovf,
   output logic [NUM_REGS*DATA_W-1:0] wr_bank,
   output logic [6:0]                 cmd_pulse,
   output logic                       tx_load,
   output logic                       chan_rst,
   output logic                       hard_rst
);

   localparam int IDX_W = $clog2(NUM_REGS);

   initial begin
      if (DATA_W != 8)              $error("scc_regif: DATA_W must be 8");
      if (NUM_REGS != 16)           $error("scc_regif: NUM_REGS must be 16");
      if (CNT_W < 9 || CNT_W > 14)  $error("scc_regif: CNT_W must lie in 9..14");
   end

   logic             armed;
   logic [IDX_W-1:0] ptr;
   logic             reg_we, chan_req, hard_req;
   logic [IDX_W-1:0] reg_idx;

   scc_regif_ptr #(.DATA_W(DATA_W), .IDX_W(IDX_W)) ptr_i (
      .clk(clk), .rst_n(rst_n),
      .acc_en(acc_en), .acc_data(acc_data), .acc_wr(acc_wr), .wdata(wdata),
      .armed(armed), .ptr(ptr),
      .reg_we(reg_we), .reg_idx(reg_idx),
      .chan_req(chan_req), .hard_req(hard_req),
      .cmd_pulse(cmd_pulse), .tx_load(tx_load),
      .chan_rst(chan_rst), .hard_rst(hard_rst)
   );

   scc_regif_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we), .idx(reg_idx), .wdata(wdata),
      .chan_req(chan_req), .hard_req(hard_req),
      .bank(wr_bank)
   );

   scc_regif_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
                     .HAS_FIFO_CNT(HAS_FIFO_CNT)) rdmux_i (
      .acc_en(acc_en), .acc_data(acc_data), .acc_wr(acc_wr),
      .armed(armed), .ptr(ptr),
      .wr_vec(wr_bank[A_VEC*DATA_W +: DATA_W]),
      .vis_en(wr_bank[A_MIC*DATA_W]),
      .wr_tcl(wr_bank[A_TCL*DATA_W +: DATA_W]),
      .wr_tch(wr_bank[A_TCH*DATA_W +: DATA_W]),
      .wr_xie(wr_bank[A_XIE*DATA_W +: DATA_W]),
      .st_rr0(st_rr0), .st_rr1(st_rr1), .st_rr10(st_rr10), .rx_byte(rx_byte),
      .ip_rx(ip_rx), .ip_tx(ip_tx), .ip_ext(ip_ext),
      .fifo_cnt(fifo_cnt), .fifo_avail(fifo_avail), .fifo_ovf(fifo_ovf),
      .rdata(rdata)
   );

endmodule

// File: rtl/scc_regif_chk.sv
module scc_regif_chk #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       acc_en,
   input logic                       acc_data,
   input logic                       acc_wr,
   input logic [DATA_W-1:0]          rdata,
   input logic                       ip_rx,
   input logic                       ip_tx,
   input logic                       ip_ext,
   input logic [NUM_REGS*DATA_W-1:0] wr_bank,
   input logic [6:0]                 cmd_pulse,
   input logic                       hard_rst,
   input logic                       armed,
   input logic [IDX_W-1:0]           ptr
);

   logic ctl_acc, ctl_rd_armed;
   assign ctl_acc      = acc_en && !acc_data;
   assign ctl_rd_armed = ctl_acc && !acc_wr && armed;

   AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_acc && armed) |=> (!armed && ptr == '0)); // R2

   AST_DATA_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_data) |=> (armed == $past(armed) && ptr == $past(ptr))); // R6

   AST_CMD_LO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_pulse[3:0])); // R3

   AST_CMD_HI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_pulse[6:4])); // R4

   AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pulse != '0) |-> $past(ctl_acc && acc_wr && !armed)); // R3

   AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst |-> (wr_bank == '0)); // R10

   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd_armed && (ptr == 4 || ptr == 5 || ptr == 9 || ptr == 11 || ptr == 14))
      |-> (rdata == '0)); // R11

   AST_IP_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd_armed && ptr == 3) |-> (rdata == {2'b00, ip_rx, ip_tx, ip_ext, 3'b000})); // R7

endmodule

bind scc_regif scc_regif_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .acc_en(acc_en), .acc_data(acc_data), .acc_wr(acc_wr), .rdata(rdata),
   .ip_rx(ip_rx), .ip_tx(ip_tx), .ip_ext(ip_ext),
   .wr_bank(wr_bank), .cmd_pulse(cmd_pulse), .hard_rst(hard_rst),
   .armed(armed), .ptr(ptr)
);

// File: tb/scc_regif_tb_top.sv
module scc_regif_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         acc_en, acc_data, acc_wr;
   logic [7:0]   wdata, rdata;
   logic [7:0]   st_rr0, st_rr1, st_rr10, rx_byte;
   logic         ip_rx, ip_tx, ip_ext;
   logic [13:0]  fifo_cnt;
   logic         fifo_avail, fifo_ovf;
   logic [127:0] wr_bank;
   logic [6:0]   cmd_pulse;
   logic         tx_load, chan_rst, hard_rst;

   always #10 clk = ~clk;

   scc_regif dut_i (
      .clk(clk), .rst_n(rst_n),
      .acc_en(acc_en), .acc_data(acc_data), .acc_wr(acc_wr),
      .wdata(wdata), .rdata(rdata),
      .st_rr0(st_rr0), .st_rr1(st_rr1), .st_rr10(st_rr10), .rx_byte(rx_byte),
      .ip_rx(ip_rx), .ip_tx(ip_tx), .ip_ext(ip_ext),
      .fifo_cnt(fifo_cnt), .fifo_avail(fifo_avail), .fifo_ovf(fifo_ovf),
      .wr_bank(wr_bank), .cmd_pulse(cmd_pulse), .tx_load(tx_load),
      .chan_rst(chan_rst), .hard_rst(hard_rst)
   );

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] m_bank [16];
   bit         m_armed;
   int         m_ptr;

   function automatic void chk(string tag, logic [127:0] got, logic [127:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endfunction

   function automatic logic [127:0] model_bank();
      logic [127:0] v;
      for (int k = 0; k < 16; k++) v[k*8 +: 8] = m_bank[k];
      return v;
   endfunction

   function automatic logic [2:0] exp_code();
      if (ip_rx)       return 3'b010;
      else if (ip_tx)  return 3'b000;
      else if (ip_ext) return 3'b001;
      return 3'b011;
   endfunction

   function automatic logic [7:0] rr_exp(int p);
      bit fen;
      fen = m_bank[15][2];
      case (p)
         0:  return st_rr0;
         1:  return st_rr1;
         2:  return m_bank[9][0] ? {m_bank[2][7:4], exp_code(), m_bank[2][0]} : m_bank[2];
         3:  return {2'b00, ip_rx, ip_tx, ip_ext, 3'b000};
         6:  return fen ? fifo_cnt[7:0] : 8'h00;
         7:  return fen ? {fifo_ovf, fifo_avail, fifo_cnt[13:8]} : 8'h00;
         8:  return rx_byte;
         10: return st_rr10;
         12: return m_bank[12];
         13: return m_bank[13];
         15: return m_bank[15];
         default: return 8'h00;
      endcase
   endfunction

   function automatic string rd_tag(int p);
      case (p)
         0: return "R2";
         2: return "R8";
         3: return "R7";
         6, 7: return "R9";
         4, 5, 9, 11, 14: return "R11";
         default: return "R12";
      endcase
   endfunction

   // one host access: drive at negedge, sample rdata mid-cycle, check registered effects next negedge
   task automatic acc(input bit dport, input bit wr, input logic [7:0] b);
      logic [7:0] exp_rd;
      logic [6:0] exp_cmd;
      bit         exp_tx, exp_ch, exp_hd;
      string      tg;
      int         p, tgt;
      st_rr0 = 8'($urandom); st_rr1 = 8'($urandom); st_rr10 = 8'($urandom);
      rx_byte = 8'($urandom); fifo_cnt = 14'($urandom);
      fifo_avail = 1'($urandom); fifo_ovf = 1'($urandom);
      ip_rx = 1'($urandom); ip_tx = 1'($urandom); ip_ext = 1'($urandom);
      p = m_armed ? m_ptr : 0;
      exp_rd = dport ? rx_byte : rr_exp(p);
      tg = dport ? "R6" : rd_tag(p);
      exp_cmd = '0; exp_tx = 0; exp_ch = 0; exp_hd = 0;
      if (!dport && wr && !m_armed) begin
         case (b[5:3])
            3'd2: exp_cmd[0] = 1'b1;
            3'd5: exp_cmd[1] = 1'b1;
            3'd6: exp_cmd[2] = 1'b1;
            3'd7: exp_cmd[3] = 1'b1;
            default: ;
         endcase
         if (b[7:6] != 2'd0) exp_cmd[3 + b[7:6]] = 1'b1;
      end
      acc_en = 1'b1; acc_data = dport; acc_wr = wr; wdata = b;
      #5;
      if (!wr) chk(tg, rdata, exp_rd);
      // model update
      if (dport) begin
         if (wr) begin m_bank[8] = b; exp_tx = 1; end
      end else if (m_armed) begin
         if (wr) begin
            if (m_ptr == 9) begin
               if (b[7:6] == 2'd3) begin
                  for (int k = 0; k < 16; k++) m_bank[k] = 8'h00;
                  exp_hd = 1;
               end else begin
                  if (b[7:6] == 2'd2) begin
                     for (int k = 1; k < 16; k++) if (k != 2) m_bank[k] = 8'h00;
                     exp_ch = 1;
                  end
                  m_bank[9] = {2'b00, b[5:0]};
               end
            end else begin
               m_bank[m_ptr] = b;
               if (m_ptr == 8) exp_tx = 1;
            end
         end
         m_armed = 0; m_ptr = 0;
      end else if (wr) begin
         tgt = b[2:0] + ((b[5:3] == 3'd1) ? 8 : 0);
         if (tgt != 0) begin m_armed = 1; m_ptr = tgt; end
      end
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0; acc_data = 1'b0;
      chk("R3", cmd_pulse[3:0], exp_cmd[3:0]);
      chk("R4", cmd_pulse[6:4], exp_cmd[6:4]);
      chk("R6", tx_load, exp_tx);
      chk("R10", {chan_rst, hard_rst}, {exp_ch, exp_hd});
      chk((exp_ch || exp_hd) ? "R10" : "R5", wr_bank, model_bank());
   endtask

   // write register r through the pointer (r in 1..15)
   task automatic wreg(input int r, input logic [7:0] v);
      acc(0, 1, (r >= 8) ? {2'b00, 3'd1, 3'(r - 8)} : {5'b0, 3'(r)});
      acc(0, 1, v);
   endtask

   task automatic rreg(input int r);
      if (r != 0) acc(0, 1, (r >= 8) ? {2'b00, 3'd1, 3'(r - 8)} : {5'b0, 3'(r)});
      acc(0, 0, 8'h00);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5CC1));
      for (int k = 0; k < 16; k++) m_bank[k] = 8'h00;
      m_armed = 0; m_ptr = 0;
      rst_n = 1'b0; acc_en = 1'b0; acc_data = 1'b0; acc_wr = 1'b0; wdata = 8'h00;
      st_rr0 = 8'h11; st_rr1 = 8'h22; st_rr10 = 8'h33; rx_byte = 8'h44;
      ip_rx = 0; ip_tx = 0; ip_ext = 0; fifo_cnt = '0; fifo_avail = 0; fifo_ovf = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13", wr_bank, 128'h0);
      chk("R13", {cmd_pulse, tx_load, chan_rst, hard_rst}, 10'h0);
      chk("R13", rdata, 8'h00);
      acc(0, 0, 8'h00);                       // R2 home read
      // R8 vector, with and without status modification
      wreg(2, 8'hA5);
      rreg(2);
      wreg(9, 8'h01);
      for (int i = 0; i < 8; i++) rreg(2);
      // R1 point high, R9 count gating
      rreg(6); rreg(7);
      wreg(15, 8'h04);
      for (int i = 0; i < 4; i++) begin rreg(6); rreg(7); end
      wreg(12, 8'h5A); wreg(13, 8'hC3);
      rreg(12); rreg(13); rreg(15); rreg(1); rreg(10); rreg(8);   // R12
      // R6 data port between pointer and access
      acc(0, 1, 8'h03); acc(1, 1, 8'h3C); acc(1, 0, 8'h00); acc(0, 0, 8'h00);
      // R11 unimplemented addresses
      rreg(4); rreg(5); rreg(9); rreg(11); rreg(14); acc(0, 0, 8'h00);
      // R3 R4 every command combination with address 0
      for (int c = 0; c < 8; c++)
         for (int h = 0; h < 4; h++) begin
            acc(0, 1, {2'(h), 3'(c), 3'b000});
            if (m_armed) acc(0, 0, 8'h00);
         end
      wreg(8, 8'h77);                          // R6 via control port
      // R10 channel then hard reset
      wreg(1, 8'hFF); wreg(3, 8'hEE); wreg(2, 8'h96);
      wreg(9, 8'h81);
      rreg(2);
      wreg(5, 8'h12); wreg(14, 8'h34);
      wreg(9, 8'hC7);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 5)      acc(0, 1, 8'($urandom));
         else if (r < 8) acc(0, 0, 8'h00);
         else if (r < 9) acc(1, 1, 8'($urandom));
         else            acc(1, 0, 8'h00);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule